// File: doc/BRIEF.md
# Floating-Point Conditional Select Unit

This block takes a 32-bit scalar floating-point conditional-select instruction word and carries it out against a local file of thirty-two 64-bit floating-point registers. The word names two source registers, a destination register, an operand precision and a 4-bit condition code. The unit checks the condition code against the four arithmetic flags (negative, zero, carry, overflow) supplied beside the word. It then copies one of the two sources into the destination at the chosen precision. The value is moved bit for bit, with no arithmetic and no rounding.

An instruction is offered by raising `in_valid` for one cycle. The register write lands on the next rising edge, and `out_done` pulses in the cycle after that edge. Words that do not match the fixed encoding, or that use the reserved precision code, are flagged on `out_illegal` together with `out_done`, and nothing is written.

A debug port reads any register combinationally. It can also load a register, so that operands can be seeded before an instruction runs.

Top module: `fp_cond_select_unit`

## Requirements
- R1: A word is legal when bits [31:24] equal 0x1E, bit 21 is 1, bits [11:10] equal 2'b11 and the type field [23:22] is 00 (32-bit single), 01 (64-bit double) or 11 (16-bit half). The other fields are Rm at [20:16], cond at [15:12], Rn at [9:5] and Rd at [4:0].
- R2: A valid word whose type field is 10, or whose fixed bits differ in any position, makes `out_illegal` and `out_done` high together in the next cycle and writes no register.
- R3: When the condition holds, register Rd receives the value of register Rn; otherwise it receives the value of register Rm.
- R4: Only register Rd changes; every other register keeps its value.
- R5: The flags are packed as N=`in_flags[3]`, Z=[2], C=[1], V=[0]. Codes 0 to 13 test, in pairs of true and inverted sense: Z set; C set; N set; V set; C set and Z clear; N equal to V; Z clear and N equal to V. Codes 14 and 15 always hold.
- R6: A single-precision move writes the low 32 bits of the source and zeroes bits [63:32]. A half-precision move writes the low 16 bits and zeroes bits [63:16]. A double-precision move writes all 64 bits.
- R7: The write lands on the first rising edge after `in_valid` is sampled high. `out_done` is high for exactly the following cycle per accepted word. An instruction in the very next cycle sees the new value.
- R8: When Rd equals Rn or Rm, the selection uses the register values from before the instruction.
- R9: A synchronous active-high `rst` clears every register, `out_done` and `out_illegal`, and suppresses any write in that cycle.
- R10: `dbg_rdata` shows register `dbg_idx` combinationally. When `dbg_we` is high and no legal instruction is being accepted, `dbg_wdata` is written to register `dbg_idx` on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_instr | input | 32 | Instruction word |
| in_flags | input | 4 | Arithmetic flags N, Z, C, V (bit 3 down to 0) |
| dbg_idx | input | 5 | Debug register index for read and write |
| dbg_we | input | 1 | Debug write strobe |
| dbg_wdata | input | 64 | Debug write data |
| dbg_rdata | output | 64 | Contents of register `dbg_idx` |
| out_done | output | 1 | One-cycle pulse after each accepted word |
| out_illegal | output | 1 | Pulses with `out_done` when the word was not legal |

## Verification
The bench runs every condition code against every flag combination at all three precisions, with freshly seeded operands each time. A design with a wrong or inverted condition, swapped sources, or a wrong flag bit order writes the wrong operand, and one that fails to clear upper bits leaves stale high bits behind. Each fixed bit and the reserved type are corrupted in turn, which catches a design that still writes on a malformed word. Aliased destinations, back-to-back dependent words and a reset that arrives while a word is offered catch stale reads, late writes and writes that slip through reset.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int INSTR_W = 32;
    localparam int DATA_W  = 64;
    localparam int NUM_REG = 32;
    localparam int IDX_W   = $clog2(NUM_REG);
    localparam int COND_W  = 4;
    localparam int FLAG_W  = 4;

    // Fixed opcode fields of the select word
    localparam logic [7:0] OPC_HI  = 8'h1E;
    localparam logic       OPC_B21 = 1'b1;
    localparam logic [1:0] OPC_LO  = 2'b11;

    typedef enum logic [1:0] {
        PREC_SGL = 2'b00,
        PREC_DBL = 2'b01,
        PREC_RSV = 2'b10,
        PREC_HLF = 2'b11
    } prec_e;

    typedef struct packed {
        logic [IDX_W-1:0]  rd;
        logic [IDX_W-1:0]  rn;
        logic [IDX_W-1:0]  rm;
        logic [COND_W-1:0] cond;
        prec_e             prec;
        logic              legal;
    } dec_t;

    typedef struct packed {
        logic done;
        logic illegal;
    } ctl_t;

endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
    import fcs_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic fixed_ok;
    logic type_ok;

    always_comb begin
        fixed_ok = (instr[31:24] == OPC_HI) &&
                   (instr[21]    == OPC_B21) &&
                   (instr[11:10] == OPC_LO);
        type_ok  = (instr[23:22] != PREC_RSV);

        dec.rd    = instr[4:0];
        dec.rn    = instr[9:5];
        dec.rm    = instr[20:16];
        dec.cond  = instr[15:12];
        dec.prec  = prec_e'(instr[23:22]);
        dec.legal = fixed_ok && type_ok;
    end

endmodule

// File: rtl/fcs_cond_eval.sv
module fcs_cond_eval
    import fcs_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [FLAG_W-1:0] flags,
    output logic              holds
);

    logic fn, fz, fc, fv;
    logic base;
    logic always_true;

    always_comb begin
        fn = flags[3];
        fz = flags[2];
        fc = flags[1];
        fv = flags[0];

        unique case (cond[3:1])
            3'd0: base = fz;
            3'd1: base = fc;
            3'd2: base = fn;
            3'd3: base = fv;
            3'd4: base = fc && !fz;
            3'd5: base = (fn == fv);
            3'd6: base = !fz && (fn == fv);
            default: base = 1'b1;
        endcase

        always_true = (cond[3:1] == 3'd7);
        holds = (cond[0] && !always_true) ? !base : base;
    end

endmodule

// File: rtl/fcs_regfile.sv
module fcs_regfile
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_addr,
    output logic [DATA_W-1:0] rb_data,
    input  logic [IDX_W-1:0]  rc_addr,
    output logic [DATA_W-1:0] rc_data
);

    logic [NUM_REG-1:0][DATA_W-1:0] mem_d;
    logic [NUM_REG-1:0][DATA_W-1:0] mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
        if (rst) begin
            mem_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    // Reads see the pre-write contents in the cycle a write is pending
    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];
    assign rc_data = mem_q[rc_addr];

    AST_IDLE_FILE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem_q)); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data))); // R7

endmodule

// File: rtl/fp_cond_select_unit.sv
module fp_cond_select_unit
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_instr,
    input  logic [3:0]        in_flags,
    input  logic [4:0]        dbg_idx,
    input  logic              dbg_we,
    input  logic [63:0]       dbg_wdata,
    output logic [63:0]       dbg_rdata,
    output logic              out_done,
    output logic              out_illegal
);

    dec_t              dec;
    logic              holds;
    logic [DATA_W-1:0] rn_val;
    logic [DATA_W-1:0] rm_val;
    logic [DATA_W-1:0] sel_val;
    logic [DATA_W-1:0] res_val;
    logic              instr_we;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_addr;
    logic [DATA_W-1:0] wr_data;
    ctl_t              ctl_d;
    ctl_t              ctl_q;

    fcs_decoder u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    fcs_cond_eval u_cond (
        .cond  (dec.cond),
        .flags (in_flags),
        .holds (holds)
    );

    fcs_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ra_addr (dec.rn),
        .ra_data (rn_val),
        .rb_addr (dec.rm),
        .rb_data (rm_val),
        .rc_addr (dbg_idx),
        .rc_data (dbg_rdata)
    );

    always_comb begin
        sel_val = holds ? rn_val : rm_val;

        unique case (dec.prec)
            PREC_HLF: res_val = {{(DATA_W-16){1'b0}}, sel_val[15:0]};
            PREC_SGL: res_val = {{(DATA_W-32){1'b0}}, sel_val[31:0]};
            PREC_DBL: res_val = sel_val;
            default:  res_val = '0;
        endcase

        instr_we = in_valid && dec.legal;

        // An accepted instruction takes the single write port over debug
        wr_en   = instr_we || dbg_we;
        wr_addr = instr_we ? dec.rd : dbg_idx;
        wr_data = instr_we ? res_val : dbg_wdata;

        ctl_d.done    = in_valid;
        ctl_d.illegal = in_valid && !dec.legal;
        if (rst) begin
            ctl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign out_done    = ctl_q.done;
    assign out_illegal = ctl_q.illegal;

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done); // R7

    AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_done); // R2

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (instr_we && dec.prec == PREC_HLF) |-> (wr_data[63:16] == '0)); // R6

    AST_SGL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (instr_we && dec.prec == PREC_SGL) |-> (wr_data[63:32] == '0)); // R6

    AST_PICKS_A_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (instr_we && dec.prec == PREC_DBL) |-> (wr_data == rn_val || wr_data == rm_val)); // R3

endmodule

// File: tb/fp_cond_select_unit_tb.sv
`timescale 1ns/1ps
module fp_cond_select_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_instr;
    logic [3:0]  in_flags;
    logic [4:0]  dbg_idx;
    logic        dbg_we;
    logic [63:0] dbg_wdata;
    logic [63:0] dbg_rdata;
    logic        out_done;
    logic        out_illegal;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [63:0] model [32];

    always #2 clk = ~clk;

    fp_cond_select_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_flags(in_flags), .dbg_idx(dbg_idx), .dbg_we(dbg_we),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .out_done(out_done), .out_illegal(out_illegal)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int k);
        return (64'h9E37_79B9_7F4A_7C15 * 64'(k + 3)) ^ 64'hC3A5_5A3C_0F0F_F0F0;
    endfunction

    function automatic bit cond_ok(input int c, input logic [3:0] f);
        bit n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            0: return z;            1: return !z;
            2: return cy;           3: return !cy;
            4: return n;            5: return !n;
            6: return v;            7: return !v;
            8: return cy && !z;     9: return !cy || z;
            10: return n == v;      11: return n != v;
            12: return !z && n == v; 13: return z || n != v;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [63:0] narrow(input int t, input logic [63:0] x);
        if (t == 3) return {48'h0, x[15:0]};
        if (t == 0) return {32'h0, x[31:0]};
        return x;
    endfunction

    function automatic logic [31:0] mk(input int t, input int rm, input int c,
                                       input int rn, input int rd);
        return {8'h1E, 2'(t), 1'b1, 5'(rm), 4'(c), 2'b11, 5'(rn), 5'(rd)};
    endfunction

    task automatic seed(input int idx, input logic [63:0] val);
        @(negedge clk);
        dbg_we = 1'b1; dbg_idx = 5'(idx); dbg_wdata = val;
        @(negedge clk);
        dbg_we = 1'b0;
        model[idx] = val;
    endtask

    task automatic read_chk(input string req, input int idx, input logic [63:0] exp);
        dbg_idx = 5'(idx);
        #1;
        check(req, dbg_rdata, exp);
    endtask

    // Issue one word; returns after sampling done/illegal in the following cycle
    task automatic issue(input logic [31:0] w, input logic [3:0] f, input bit exp_ill);
        @(negedge clk);
        in_valid = 1'b1; in_instr = w; in_flags = f;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 done", {63'h0, out_done}, 64'h1);
        check("R2 illegal flag", {63'h0, out_illegal}, {63'h0, exp_ill});
    endtask

    initial begin
        #(4.0 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_flags = '0;
        dbg_idx = '0; dbg_we = 1'b0; dbg_wdata = '0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check("R9 done after reset", {63'h0, out_done}, 64'h0);
        check("R9 illegal after reset", {63'h0, out_illegal}, 64'h0);
        for (int i = 0; i < 32; i++) read_chk("R9 reg cleared", i, 64'h0);

        // R10 debug load and read
        for (int i = 0; i < 32; i++) seed(i, pat(i * 7));
        for (int i = 0; i < 32; i++) read_chk("R10 debug readback", i, model[i]);

        // Full sweep: R1 R3 R4 R5 R6 R8
        for (int ti = 0; ti < 3; ti++) begin
            for (int c = 0; c < 16; c++) begin
                for (int fi = 0; fi < 16; fi++) begin
                    int t, rd, rn, rm, spy;
                    logic [63:0] exp;
                    t   = (ti == 2) ? 3 : ti;
                    rd  = (c * 7 + fi * 3 + t) % 32;
                    rn  = (c + fi * 5 + 1) % 32;
                    rm  = (fi + c * 11 + t * 3 + 2) % 32;
                    spy = (rd + 13) % 32;
                    seed(rn, pat(c * 256 + fi * 16 + ti));
                    if (rm != rn) seed(rm, ~pat(c * 512 + fi * 8 + ti + 1));
                    exp = narrow(t, cond_ok(c, 4'(fi)) ? model[rn] : model[rm]);
                    issue(mk(t, rm, c, rn, rd), 4'(fi), 1'b0);
                    model[rd] = exp;
                    read_chk("R3 R5 R6 selected value", rd, exp);
                    read_chk("R4 other register untouched", spy, model[spy]);
                end
            end
        end

        // R8 destination aliases a source
        seed(5, 64'hDEAD_BEEF_1234_5678);
        seed(6, 64'h0BAD_F00D_CAFE_0001);
        issue(mk(0, 6, 14, 5, 5), 4'h0, 1'b0);
        read_chk("R8 rd equals rn", 5, 64'h0000_0000_1234_5678);
        seed(5, 64'h1111_2222_3333_4444);
        issue(mk(3, 5, 0, 6, 5), 4'h0, 1'b0);
        read_chk("R8 rd equals rm", 5, 64'h0000_0000_0000_4444);

        // R7 back-to-back dependent words
        seed(11, 64'hA1B2_C3D4_E5F6_0718);
        seed(10, 64'h0);
        seed(12, 64'h0);
        @(negedge clk);
        in_valid = 1'b1; in_instr = mk(1, 0, 14, 11, 10); in_flags = 4'h0;
        @(negedge clk);
        check("R7 first done", {63'h0, out_done}, 64'h1);
        in_instr = mk(1, 0, 14, 10, 12);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 second done", {63'h0, out_done}, 64'h1);
        read_chk("R7 dependent read sees new value", 12, 64'hA1B2_C3D4_E5F6_0718);
        @(negedge clk);
        check("R7 done is a pulse", {63'h0, out_done}, 64'h0);

        // R2 reserved type
        seed(3, 64'h5555_AAAA_5555_AAAA);
        issue(mk(2, 4, 14, 4, 3), 4'h0, 1'b1);
        read_chk("R2 reserved type no write", 3, 64'h5555_AAAA_5555_AAAA);

        // R1 R2 each fixed bit corrupted
        for (int k = 0; k < 11; k++) begin
            int pos;
            logic [31:0] w;
            pos = (k < 8) ? 31 - k : (k == 8) ? 21 : (k == 9) ? 11 : 10;
            w = mk(1, 4, 14, 4, 3);
            w[pos] = ~w[pos];
            issue(w, 4'h0, 1'b1);
            read_chk("R1 fixed bit mismatch no write", 3, 64'h5555_AAAA_5555_AAAA);
        end

        // R9 reset while a word is offered
        seed(7, 64'hFFFF_0000_FFFF_0000);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_instr = mk(1, 7, 14, 7, 8);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R9 done cleared", {63'h0, out_done}, 64'h0);
        read_chk("R9 no write under reset", 8, 64'h0);
        read_chk("R9 file cleared", 7, 64'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule